// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Combiner

This block merges the interrupt requests of two disk channels into one level-sensitive interrupt line for a host bus. Each channel owns a pending flag and a block flag, both held in one shared mode byte at configuration offset 0x71. A channel's pending flag follows the edges of its request line: it sets when the request rises and clears when the request falls. Software can also clear a pending flag by writing a one to it through the configuration path. The host interrupt is asserted while any channel is pending and not blocked.

Each pending flag is also reflected into an older status byte: channel 0 into offset 0x50 and channel 1 into offset 0x57. The remaining bits of those two bytes are plain storage that configuration writes can load. The block flags cannot be written from the configuration path. They are loaded through a separate mask-write port, which in the wider controller belongs to the DMA register window. A combinational read port returns any of the three bytes.

Top module: `ide_irq_agg`

## Requirements
- R1: While reset is held and right after it, all pending and block flags and all stored status bits are zero, `irqOut` is low, and reads of 0x71, 0x50 and 0x57 return 0x00.
- R2: A rising edge on `chReq[c]` sets channel c's pending flag at the clock edge that samples it. In the mode byte at 0x71, channel 0's pending flag is bit 2 and channel 1's is bit 3.
- R3: A falling edge on `chReq[c]` clears channel c's pending flag at the clock edge that samples it.
- R4: `irqOut` is a register. After every clock edge it equals (pend0 AND NOT blk0) OR (pend1 AND NOT blk1), computed from the flag values that edge produced.
- R5: A configuration write to 0x71 clears every pending flag whose data bit (bit 2 or 3) is 1. Pending flags whose data bit is 0 are left unchanged.
- R6: A configuration write to 0x71 never changes the block flags (bits 4 and 5). Bits 0, 1, 6 and 7 of 0x71 always read as 0.
- R7: Bit 2 of 0x50 always reads as channel 0's pending flag, and bit 4 of 0x57 always reads as channel 1's.
- R8: A configuration write to 0x50 or 0x57 stores every data bit except the mirror bit (bit 2 or bit 4, respectively). The mirror bit keeps showing the pending flag.
- R9: A mask write loads `blkWrData[4]` into channel 0's block flag and `blkWrData[5]` into channel 1's. It leaves the pending flags unchanged.
- R10: If a request edge and a write-one clear hit the same pending flag in the same cycle, the request edge decides the new value.
- R11: A request held at a constant level does not change its pending flag. A flag cleared by software while its request stays high remains clear.
- R12: Reads of any other offset return 0x00, and configuration writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chReq | input | 2 | Per-channel interrupt request levels |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgWrAddr | input | 8 | Configuration write offset |
| cfgWrData | input | 8 | Configuration write data |
| blkWrEn | input | 1 | Mask-write strobe |
| blkWrData | input | 8 | Mask-write data; bits 5:4 are used |
| cfgRdAddr | input | 8 | Read offset |
| cfgRdData | output | 8 | Combinational read data |
| irqOut | output | 1 | Registered host interrupt level |

## Verification
The edge-based properties depend on `chReq` being synchronous to `clk` and holding steady between edges. They are only armed from the second edge after reset, so a request that is already high at reset release is not mistaken for a missing rise. The stimulus changes requests, writes and the read offset only on falling edges. It keeps every request at a fixed level throughout reset. Mask and configuration writes may land in the same cycle as each other and as request edges, because the properties for those cases exclude only the overlaps the design defines separately.

// File: rtl/ide_irq_agg_pkg.sv
package ide_irq_agg_pkg;
  localparam int NUM_CH   = 2;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int PEND_LSB = 2;
  localparam int BLK_LSB  = 4;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 8'h71;
  localparam logic [ADDR_W-1:0] LEG0_ADDR = 8'h50;
  localparam logic [ADDR_W-1:0] LEG1_ADDR = 8'h57;
  localparam int LEG0_BIT = 2;
  localparam int LEG1_BIT = 4;

  typedef struct packed {
    logic [NUM_CH-1:0] reqEvt;
    logic [NUM_CH-1:0] reqLvl;
    logic [NUM_CH-1:0] clrPend;
    logic              blkLoad;
    logic [NUM_CH-1:0] blkVal;
    logic [NUM_CH-1:0] legLoad;
    logic [DATA_W-1:0] legData;
  } strobes_t;

  function automatic logic [ADDR_W-1:0] legAddr(input int ch);
    return (ch == 0) ? LEG0_ADDR : LEG1_ADDR;
  endfunction

  function automatic int mirBit(input int ch);
    return (ch == 0) ? LEG0_BIT : LEG1_BIT;
  endfunction
endpackage

// File: rtl/ide_irq_agg_ctrl.sv
module ide_irq_agg_ctrl
  import ide_irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgWrAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              blkWrEn,
  input  logic [DATA_W-1:0] blkWrData,
  output strobes_t          strb
);
  logic [NUM_CH-1:0] reqPrevQ;
  logic              modeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPrevQ <= '0;
    else       reqPrevQ <= chReq;
  end

  assign modeHit = cfgWrEn && (cfgWrAddr == MODE_ADDR);

  always_comb begin
    strb = '0;
    strb.reqLvl  = chReq;
    strb.reqEvt  = chReq ^ reqPrevQ;
    strb.blkLoad = blkWrEn;
    strb.legData = cfgWrData;
    for (int c = 0; c < NUM_CH; c++) begin
      strb.clrPend[c] = modeHit && cfgWrData[PEND_LSB + c];
      strb.blkVal[c]  = blkWrData[BLK_LSB + c];
      strb.legLoad[c] = cfgWrEn && (cfgWrAddr == legAddr(c));
    end
  end
endmodule

// File: rtl/ide_irq_agg_dp.sv
module ide_irq_agg_dp
  import ide_irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] cfgRdAddr,
  output logic [DATA_W-1:0] cfgRdData,
  output logic [NUM_CH-1:0] pendQ,
  output logic [NUM_CH-1:0] blkQ,
  output logic              irqQ
);
  logic [NUM_CH-1:0] pendNext;
  logic [NUM_CH-1:0] blkNext;
  logic [DATA_W-1:0] legQ    [NUM_CH];
  logic [DATA_W-1:0] legNext [NUM_CH];

  always_comb begin
    blkNext = strb.blkLoad ? strb.blkVal : blkQ;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strb.reqEvt[c])       pendNext[c] = strb.reqLvl[c];
      else if (strb.clrPend[c]) pendNext[c] = 1'b0;
      else                      pendNext[c] = pendQ[c];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gLeg
      localparam logic [DATA_W-1:0] MIR_MASK = DATA_W'(1) << mirBit(g);
      assign legNext[g] = strb.legLoad[g] ? (strb.legData & ~MIR_MASK) : legQ[g];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) legQ[g] <= '0;
        else       legQ[g] <= legNext[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      blkQ  <= '0;
      irqQ  <= 1'b0;
    end else begin
      pendQ <= pendNext;
      blkQ  <= blkNext;
      irqQ  <= |(pendNext & ~blkNext);
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgRdAddr == MODE_ADDR) begin
      for (int c = 0; c < NUM_CH; c++) begin
        cfgRdData[PEND_LSB + c] = pendQ[c];
        cfgRdData[BLK_LSB + c]  = blkQ[c];
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (cfgRdAddr == legAddr(c)) begin
        cfgRdData = legQ[c];
        cfgRdData[mirBit(c)] = pendQ[c];
      end
    end
  end
endmodule

// File: rtl/ide_irq_agg.sv
module ide_irq_agg
  import ide_irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgWrAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              blkWrEn,
  input  logic [DATA_W-1:0] blkWrData,
  input  logic [ADDR_W-1:0] cfgRdAddr,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              irqOut
);
  strobes_t          strb;
  logic [NUM_CH-1:0] pendQ;
  logic [NUM_CH-1:0] blkQ;

  ide_irq_agg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .chReq(chReq),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .blkWrEn(blkWrEn), .blkWrData(blkWrData), .strb(strb)
  );

  ide_irq_agg_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData),
    .pendQ(pendQ), .blkQ(blkQ), .irqQ(irqOut)
  );
endmodule

// File: rtl/ide_irq_agg_chk.sv
module ide_irq_agg_chk
  import ide_irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chReq,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgWrAddr,
  input logic [DATA_W-1:0] cfgWrData,
  input logic              blkWrEn,
  input logic [NUM_CH-1:0] pendQ,
  input logic [NUM_CH-1:0] blkQ,
  input logic              irqOut
);
  logic armed;
  logic modeWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign modeWr = cfgWrEn && (cfgWrAddr == MODE_ADDR);

  // R4: registered output tracks the masked OR of the stored flags
  a_r4_masked_or: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(pendQ & ~blkQ));

  // R6: configuration path never alters the block flags
  a_r6_blk_read_only: assert property (@(posedge clk) disable iff (!rstN)
    modeWr && !blkWrEn |=> $stable(blkQ));

  // R9: mask writes leave pending flags alone
  a_r9_mask_keeps_pend: assert property (@(posedge clk) disable iff (!rstN)
    armed && blkWrEn && !modeWr && $stable(chReq) |=> $stable(pendQ));

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : gCh
      // R2
      a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
        armed && $rose(chReq[c]) |=> pendQ[c]);
      // R3
      a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rstN)
        armed && $fell(chReq[c]) |=> !pendQ[c]);
      // R5
      a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
        armed && $stable(chReq[c]) && modeWr && cfgWrData[PEND_LSB + c] |=> !pendQ[c]);
      // R10
      a_r10_req_wins: assert property (@(posedge clk) disable iff (!rstN)
        armed && $rose(chReq[c]) && modeWr && cfgWrData[PEND_LSB + c] |=> pendQ[c]);
      // R11
      a_r11_level_hold: assert property (@(posedge clk) disable iff (!rstN)
        armed && $stable(chReq[c]) && !(modeWr && cfgWrData[PEND_LSB + c]) |=> $stable(pendQ[c]));
    end
  endgenerate
endmodule

bind ide_irq_agg ide_irq_agg_chk chk_i (
  .clk(clk), .rstN(rstN), .chReq(chReq),
  .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
  .blkWrEn(blkWrEn), .pendQ(pendQ), .blkQ(blkQ), .irqOut(irqOut)
);

// File: tb/ide_irq_agg_tb.sv
module ide_irq_agg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] chReq = '0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       blkWrEn = 1'b0;
  logic [7:0] blkWrData = '0;
  logic [7:0] cfgRdAddr = '0;
  logic [7:0] cfgRdData;
  logic       irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  // behavioural model state
  bit mPend[2];
  bit mBlk[2];
  bit mPrev[2];
  byte unsigned mLeg[2];
  bit mIrq;

  always #5 clk = ~clk;

  ide_irq_agg dut_i (
    .clk(clk), .rstN(rstN), .chReq(chReq),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .blkWrEn(blkWrEn), .blkWrData(blkWrData),
    .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData), .irqOut(irqOut)
  );

  function automatic byte unsigned expRead(input byte unsigned a);
    byte unsigned v = 0;
    if (a == 8'h71) v = (8'(mPend[0]) << 2) | (8'(mPend[1]) << 3) | (8'(mBlk[0]) << 4) | (8'(mBlk[1]) << 5);
    else if (a == 8'h50) v = mLeg[0] | (8'(mPend[0]) << 2);
    else if (a == 8'h57) v = mLeg[1] | (8'(mPend[1]) << 4);
    return v;
  endfunction

  task automatic compare(input string tag);
    byte unsigned e = expRead(cfgRdAddr);
    testsRun++;
    if (irqOut !== mIrq) begin
      testsFailed++;
      $display("FAIL %s irqOut actual=%0b expected=%0b", tag, irqOut, mIrq);
    end
    testsRun++;
    if (cfgRdData !== e) begin
      testsFailed++;
      $display("FAIL %s read @%02h actual=%02h expected=%02h", tag, cfgRdAddr, cfgRdData, e);
    end
  endtask

  task automatic modelEdge();
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mPend[c] = 0; mBlk[c] = 0; mPrev[c] = 0; mLeg[c] = 0;
      end
      mIrq = 0;
      return;
    end
    for (int c = 0; c < 2; c++) begin
      if (chReq[c] != mPrev[c]) mPend[c] = chReq[c];
      else if (cfgWrEn && cfgWrAddr == 8'h71 && cfgWrData[2 + c]) mPend[c] = 0;
      mPrev[c] = chReq[c];
      if (blkWrEn) mBlk[c] = blkWrData[4 + c];
    end
    if (cfgWrEn && cfgWrAddr == 8'h50) mLeg[0] = cfgWrData & 8'hFB;
    if (cfgWrEn && cfgWrAddr == 8'h57) mLeg[1] = cfgWrData & 8'hEF;
    mIrq = (mPend[0] && !mBlk[0]) || (mPend[1] && !mBlk[1]);
  endtask

  // drive at the falling edge, check the settled state, then advance the model
  task automatic step(input string tag, input logic [1:0] req, input logic wr,
                      input logic [7:0] wa, input logic [7:0] wd,
                      input logic bw, input logic [7:0] bd, input logic [7:0] ra);
    @(negedge clk);
    chReq = req; cfgWrEn = wr; cfgWrAddr = wa; cfgWrData = wd;
    blkWrEn = bw; blkWrData = bd; cfgRdAddr = ra;
    #1;
    compare(tag);
    @(posedge clk);
    modelEdge();
  endtask

  task automatic idle(input string tag, input logic [1:0] req, input logic [7:0] ra);
    step(tag, req, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, ra);
  endtask

  initial begin
    modelEdge();
    // R1: reset state on all three registers
    idle("R1", 2'b00, 8'h71);
    idle("R1", 2'b00, 8'h50);
    idle("R1", 2'b00, 8'h57);
    @(negedge clk); rstN = 1'b1;
    idle("R1", 2'b00, 8'h71);
    // R2: rising edges set pending, R4 output follows, R7 mirrors
    idle("R2", 2'b01, 8'h71);
    idle("R2", 2'b01, 8'h71);
    idle("R7", 2'b11, 8'h50);
    idle("R7", 2'b11, 8'h57);
    idle("R2", 2'b11, 8'h71);
    // R9/R4: block channel 0, then both, then release
    step("R9", 2'b11, 1'b0, 8'h00, 8'h00, 1'b1, 8'h10, 8'h71);
    step("R4", 2'b11, 1'b0, 8'h00, 8'h00, 1'b1, 8'h30, 8'h71);
    idle("R4", 2'b11, 8'h71);
    step("R9", 2'b11, 1'b0, 8'h00, 8'h00, 1'b1, 8'hCF, 8'h71);
    idle("R4", 2'b11, 8'h71);
    // R3: falling edge clears
    idle("R3", 2'b10, 8'h71);
    idle("R3", 2'b10, 8'h50);
    // R6: write all ones to mode byte clears pending, block unchanged
    step("R6", 2'b10, 1'b0, 8'h00, 8'h00, 1'b1, 8'h20, 8'h71);
    step("R6", 2'b10, 1'b1, 8'h71, 8'hFF, 1'b0, 8'h00, 8'h71);
    idle("R6", 2'b10, 8'h71);
    // R11: request still high, flag stays clear
    idle("R11", 2'b10, 8'h71);
    idle("R11", 2'b10, 8'h57);
    step("R9", 2'b10, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 8'h71);
    // R5: selective clear
    idle("R5", 2'b00, 8'h71);
    idle("R5", 2'b11, 8'h71);
    step("R5", 2'b11, 1'b1, 8'h71, 8'h08, 1'b0, 8'h00, 8'h71);
    idle("R5", 2'b11, 8'h71);
    step("R5", 2'b11, 1'b1, 8'h71, 8'h04, 1'b0, 8'h00, 8'h71);
    idle("R5", 2'b11, 8'h71);
    // R10: edge and clear together
    idle("R10", 2'b00, 8'h71);
    step("R10", 2'b01, 1'b1, 8'h71, 8'h0C, 1'b0, 8'h00, 8'h71);
    idle("R10", 2'b01, 8'h71);
    step("R10", 2'b11, 1'b1, 8'h71, 8'h08, 1'b0, 8'h00, 8'h71);
    idle("R10", 2'b11, 8'h71);
    // R8: status byte storage with mirror bit protected
    step("R8", 2'b11, 1'b1, 8'h50, 8'hFF, 1'b0, 8'h00, 8'h50);
    step("R8", 2'b11, 1'b1, 8'h57, 8'hFF, 1'b0, 8'h00, 8'h50);
    idle("R8", 2'b11, 8'h57);
    idle("R8", 2'b00, 8'h50);
    idle("R8", 2'b00, 8'h57);
    // R12: unmapped write and read
    step("R12", 2'b00, 1'b1, 8'h33, 8'hFF, 1'b0, 8'h00, 8'h33);
    idle("R12", 2'b00, 8'h33);
    idle("R12", 2'b00, 8'h50);
    idle("R12", 2'b00, 8'h71);
    // mixed traffic across R2..R12
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] addrs[5] = '{8'h71, 8'h50, 8'h57, 8'h33, 8'h70};
      step("R4", 2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0),
           addrs[$urandom_range(0, 4)], 8'($urandom_range(0, 255)),
           1'($urandom_range(0, 7) == 0), 8'($urandom_range(0, 255)),
           addrs[$urandom_range(0, 4)]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule